// File: doc/BRIEF.md
# Mode-Configurable GPIO Port

This block is an eight-pin general-purpose I/O port. A small register bus reaches two registers: a data register with one bit per pin, and a mode register with a two-bit field per pin. Each pin's field selects one of four roles. The pin can be handed to an alternate peripheral, driven as a general output, or used as an input with the pull-up on or off.

For each pin the block produces a pad output value, a pad output enable and a pull-up enable, and it takes in the pad's input level. In alternate mode the peripheral's output value and enable pass straight through to the pad. A read of the data register returns either the stored bit or the synchronized pin level, chosen by each pin's mode. A write always lands in storage, but it reaches the pad only for pins in output mode.

Top module: `gpio_modeport`

## Requirements
- R1: After synchronous reset, the data register reads 0x0000 (address 0) and the mode register reads 0x0000 (address 1), so every pin is in alternate mode.
- R2: A write to address 1 stores all 16 bits of the mode register, which reads back unchanged. Pin n's mode sits in bits 2n+1:2n, with codes 00 alternate, 01 output, 10 input with pull-up, 11 input without pull-up.
- R3: A read of address 0 returns the stored data bit in bit n for every pin n in mode 00 or 01.
- R4: A read of address 0 returns the pin level in bit n for every pin n in mode 10 or 11. The level passes through a two-flop synchronizer, so a change made between two rising edges is visible after the second of the next two rising edges.
- R5: A write to address 0 updates all eight stored data bits whatever the pin modes are. Bits that were written while their pins were in input mode appear on the pads once those pins switch to output mode.
- R6: A pin in mode 01 has pad_oe high and pad_out equal to its stored data bit.
- R7: A pin in mode 00 has pad_out equal to alt_out and pad_oe equal to alt_oe.
- R8: A pin in mode 10 or 11 has pad_oe low and pad_out low, and writes to the data register leave its pad unchanged.
- R9: pad_pu is high for a pin exactly when its mode is 10.
- R10: A mode write takes effect at the rising edge that completes it. Before that edge the pad keeps the old mode's drive, and from that edge on both the drive and the read source follow the new mode.
- R11: Bits 15:8 of a read at address 0 are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 1 | Register select: 0 data, 1 mode |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data (data register uses bits 7:0) |
| reg_rdata | output | 16 | Read data for the selected register |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| alt_out | input | 8 | Alternate-function output values |
| alt_oe | input | 8 | Alternate-function output enables |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad pull-up enables |

## Verification
On every cycle, the assertions check the per-pin drive rules for each mode, the pull-up enable, the storing of both registers one edge after a write, the reset values, and the agreement between input-mode read bits and the pin level from two edges earlier. The bench's scenarios are needed for the rest. Only they show that data written while a pin is an input comes out once the pin becomes an output. Only they show that the old drive still holds during the cycle a mode write is issued. Only they show the exact edge at which a pin change first appears in read data, and how mixed modes across the port combine in one read word.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int MODE_BITS = 2;

    typedef enum logic [MODE_BITS-1:0] {
        PM_ALT     = 2'b00,
        PM_OUT     = 2'b01,
        PM_IN_PULL = 2'b10,
        PM_IN_FLT  = 2'b11
    } pin_mode_e;

    typedef struct packed {
        logic drv;
        logic en;
        logic pull;
    } pad_ctl_t;

    // Input roles read the pin; the other roles read storage.
    function automatic logic mode_reads_pin(pin_mode_e m);
        return (m == PM_IN_PULL) || (m == PM_IN_FLT);
    endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       data_we,
    input  logic                       mode_we,
    input  logic [MODE_BITS*NPINS-1:0] wdata,
    output logic [NPINS-1:0]           data_q,
    output logic [MODE_BITS*NPINS-1:0] mode_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            mode_q <= '0;
        end else begin
            if (data_we) data_q <= wdata[NPINS-1:0];
            if (mode_we) mode_q <= wdata;
        end
    end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int NPINS  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] async_in,
    output logic [NPINS-1:0] sync_out
);

    logic [NPINS-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[0] <= '0;
                else     stage_q[0] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_port_pkg::*;
(
    input  logic [MODE_BITS-1:0] mode,
    input  logic                 data_bit,
    input  logic                 pin_lvl,
    input  logic                 alt_o,
    input  logic                 alt_en,
    output logic                 pad_o,
    output logic                 pad_en,
    output logic                 pad_pull,
    output logic                 rd_bit
);

    pin_mode_e m;
    pad_ctl_t  ctl;

    assign m = pin_mode_e'(mode);

    always_comb begin
        ctl = '0;
        unique case (m)
            PM_ALT:     begin ctl.drv = alt_o;    ctl.en = alt_en; end
            PM_OUT:     begin ctl.drv = data_bit; ctl.en = 1'b1;   end
            PM_IN_PULL: ctl.pull = 1'b1;
            PM_IN_FLT:  ctl = '0;
            default:    ctl = '0;
        endcase
    end

    assign pad_o    = ctl.drv;
    assign pad_en   = ctl.en;
    assign pad_pull = ctl.pull;
    assign rd_bit   = mode_reads_pin(m) ? pin_lvl : data_bit;

endmodule

// File: rtl/gpio_modeport.sv
module gpio_modeport
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       reg_addr,
    input  logic                       reg_wr,
    input  logic [MODE_BITS*NPINS-1:0] reg_wdata,
    output logic [MODE_BITS*NPINS-1:0] reg_rdata,
    input  logic [NPINS-1:0]           pin_in,
    input  logic [NPINS-1:0]           alt_out,
    input  logic [NPINS-1:0]           alt_oe,
    output logic [NPINS-1:0]           pad_out,
    output logic [NPINS-1:0]           pad_oe,
    output logic [NPINS-1:0]           pad_pu
);

    localparam int BUS_W = MODE_BITS * NPINS;

    logic [NPINS-1:0] data_q;
    logic [BUS_W-1:0] mode_q;
    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] rd_bits;

    gpio_regs #(.NPINS(NPINS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .data_we (reg_wr && !reg_addr),
        .mode_we (reg_wr &&  reg_addr),
        .wdata   (reg_wdata),
        .data_q  (data_q),
        .mode_q  (mode_q)
    );

    gpio_sync #(.NPINS(NPINS), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_pin_ctrl u_pin (
            .mode     (mode_q[MODE_BITS*i +: MODE_BITS]),
            .data_bit (data_q[i]),
            .pin_lvl  (pin_sync[i]),
            .alt_o    (alt_out[i]),
            .alt_en   (alt_oe[i]),
            .pad_o    (pad_out[i]),
            .pad_en   (pad_oe[i]),
            .pad_pull (pad_pu[i]),
            .rd_bit   (rd_bits[i])
        );
    end

    always_comb begin
        if (reg_addr) reg_rdata = mode_q;
        else          reg_rdata = {{(BUS_W-NPINS){1'b0}}, rd_bits};
    end

endmodule

// File: rtl/gpio_modeport_chk.sv
module gpio_modeport_chk #(
    parameter int NPINS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 reg_addr,
    input logic                 reg_wr,
    input logic [2*NPINS-1:0]   reg_wdata,
    input logic [2*NPINS-1:0]   reg_rdata,
    input logic [NPINS-1:0]     pin_in,
    input logic [NPINS-1:0]     alt_out,
    input logic [NPINS-1:0]     alt_oe,
    input logic [NPINS-1:0]     pad_out,
    input logic [NPINS-1:0]     pad_oe,
    input logic [NPINS-1:0]     pad_pu,
    input logic [NPINS-1:0]     data_q,
    input logic [2*NPINS-1:0]   mode_q
);

    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (data_q == '0) && (mode_q == '0));

    a_r2_mode_store: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr) |=> (mode_q == $past(reg_wdata)));

    a_r5_data_store: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_addr) |=> (data_q == $past(reg_wdata[NPINS-1:0])));

    a_r11_upper_zero: assert property (@(posedge clk) disable iff (rst)
        !reg_addr |-> (reg_rdata[2*NPINS-1:NPINS] == '0));

    for (genvar i = 0; i < NPINS; i++) begin : g_chk
        a_r6_out_drive: assert property (@(posedge clk) disable iff (rst)
            (mode_q[2*i +: 2] == 2'b01) |-> (pad_oe[i] && (pad_out[i] == data_q[i])));

        a_r7_alt_pass: assert property (@(posedge clk) disable iff (rst)
            (mode_q[2*i +: 2] == 2'b00) |-> ((pad_out[i] == alt_out[i]) && (pad_oe[i] == alt_oe[i])));

        a_r8_input_quiet: assert property (@(posedge clk) disable iff (rst)
            mode_q[2*i+1] |-> (!pad_oe[i] && !pad_out[i]));

        a_r9_pullup: assert property (@(posedge clk) disable iff (rst)
            pad_pu[i] == (mode_q[2*i +: 2] == 2'b10));

        a_r3_stored_read: assert property (@(posedge clk) disable iff (rst)
            (!reg_addr && !mode_q[2*i+1]) |-> (reg_rdata[i] == data_q[i]));

        a_r4_pin_read: assert property (@(posedge clk) disable iff (rst)
            (!reg_addr && mode_q[2*i+1] && !$past(rst) && !$past(rst, 2))
                |-> (reg_rdata[i] == $past(pin_in[i], 2)));
    end

endmodule

bind gpio_modeport gpio_modeport_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pin_in    (pin_in),
    .alt_out   (alt_out),
    .alt_oe    (alt_oe),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu),
    .data_q    (data_q),
    .mode_q    (mode_q)
);

// File: tb/gpio_modeport_tb.sv
module gpio_modeport_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_addr = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  alt_out = '0;
    logic [7:0]  alt_oe = '0;
    logic [7:0]  pad_out, pad_oe, pad_pu;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_modeport u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .alt_out(alt_out), .alt_oe(alt_oe), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    // mode, data, pins, alt_out, alt_oe | exp pad_out, pad_oe, pad_pu, read
    typedef struct packed {
        logic [15:0] mode;
        logic [7:0]  data;
        logic [7:0]  pins;
        logic [7:0]  aout;
        logic [7:0]  aoe;
        logic [7:0]  e_out;
        logic [7:0]  e_oe;
        logic [7:0]  e_pu;
        logic [7:0]  e_rd;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{16'h5555, 8'hA5, 8'h0F, 8'hFF, 8'hFF, 8'hA5, 8'hFF, 8'h00, 8'hA5},
        '{16'h0000, 8'h3C, 8'hF0, 8'h96, 8'h0F, 8'h96, 8'h0F, 8'h00, 8'h3C},
        '{16'hAAAA, 8'hFF, 8'h5A, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'h5A},
        '{16'hFFFF, 8'h00, 8'hC3, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hC3},
        '{16'hFA05, 8'h6E, 8'h96, 8'h08, 8'h04, 8'h0A, 8'h07, 8'h30, 8'h9E}
    };

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic a, logic [15:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_addr  = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        alt_out = 8'h5C;
        alt_oe  = 8'hC5;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset values, alternate mode on all pins
        reg_addr = 1'b0;
        #1 check("R1 data", reg_rdata, 16'h0000);
        reg_addr = 1'b1;
        #1 check("R1 mode", reg_rdata, 16'h0000);
        reg_addr = 1'b0;
        check("R1/R7 pad_out", {8'h0, pad_out}, {8'h0, 8'h5C});
        check("R1/R7 pad_oe",  {8'h0, pad_oe},  {8'h0, 8'hC5});

        // Vector table: R2 R3 R4 R6 R7 R8 R9 R11
        for (int k = 0; k < NVEC; k++) begin
            bus_write(1'b1, VECS[k].mode);
            reg_addr = 1'b1;
            #1 check("R2 mode readback", reg_rdata, VECS[k].mode);
            reg_addr = 1'b0;
            bus_write(1'b0, {8'h00, VECS[k].data});
            pin_in  = VECS[k].pins;
            alt_out = VECS[k].aout;
            alt_oe  = VECS[k].aoe;
            repeat (2) @(negedge clk);
            #1;
            check("R6/R7/R8 pad_out", {8'h0, pad_out}, {8'h0, VECS[k].e_out});
            check("R6/R7/R8 pad_oe",  {8'h0, pad_oe},  {8'h0, VECS[k].e_oe});
            check("R9 pad_pu",        {8'h0, pad_pu},  {8'h0, VECS[k].e_pu});
            check("R3/R4/R11 read",   reg_rdata,       {8'h0, VECS[k].e_rd});
        end

        // R4: two-edge latency on a pin change (all pins input, no pull)
        bus_write(1'b1, 16'hFFFF);
        pin_in = 8'h00;
        repeat (3) @(negedge clk);
        pin_in = 8'hA1;
        @(negedge clk);
        #1 check("R4 after one edge", reg_rdata, 16'h0000);
        @(negedge clk);
        #1 check("R4 after two edges", reg_rdata, 16'h00A1);

        // R5/R8: write in input mode lands in storage, pads stay quiet
        bus_write(1'b0, 16'h005A);
        #1 check("R8 pad_out after write", {8'h0, pad_out}, 16'h0000);
        check("R5 read shows pins", reg_rdata, 16'h00A1);
        bus_write(1'b1, 16'h5555);
        #1 check("R5 stored data on pads", {8'h0, pad_out}, 16'h005A);
        check("R5 stored data read", reg_rdata, 16'h005A);

        // R10: mode change from alternate to output on pin 0 only
        bus_write(1'b1, 16'h0000);
        alt_out = 8'h00;
        alt_oe  = 8'h00;
        bus_write(1'b0, 16'h00FF);
        @(negedge clk);
        reg_addr  = 1'b1;
        reg_wdata = 16'h0001;
        reg_wr    = 1'b1;
        #1 check("R10 old drive before edge", {8'h0, pad_oe}, 16'h0000);
        @(negedge clk);
        reg_wr   = 1'b0;
        reg_addr = 1'b0;
        #1 check("R10 new drive after edge", {8'h0, pad_oe}, 16'h0001);
        check("R10 new pad_out", {8'h0, pad_out}, 16'h0001);

        // R1: reset in mid-run clears both registers
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        reg_addr = 1'b1;
        #1 check("R1 mode after reset", reg_rdata, 16'h0000);
        reg_addr = 1'b0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule